// File: doc/BRIEF.md
# Decimal Ten's-Complement Subtractor

This block subtracts one unsigned packed-BCD number from another, M minus N, in purely combinational logic. Rather than a dedicated decimal borrow chain, it inverts every digit of N to its nine's complement and feeds the add-one of the ten's complement in as the carry into the least significant digit. It then sums the result with M through a ripple of decimal digit adders, each of which applies the usual plus-six correction.

The carry leaving the most significant digit decides the sign. When that carry is present, M is at least N and the digit sum is already the answer. When it is absent, the true result is negative. A second pass then takes the ten's complement of the digit sum, so the output is always a sign flag plus a BCD magnitude. A separate flag reports any operand digit outside the legal decimal range, and the magnitude is meaningless while that flag is set.

The operand width is set by the digit count parameter `DIGITS`, which defaults to 4. In every packed vector, digit k occupies bits [4k+3:4k], and digit 0 is the least significant.

Top module: `bcd_tens_subtractor`

## Requirements
- R1: When M >= N and both operands are legal BCD, diff_mag equals M - N in BCD and diff_neg is 0.
- R2: When M < N and both operands are legal BCD, diff_neg is 1 and diff_mag equals N - M in BCD.
- R3: When M equals N, diff_mag is all zero and diff_neg is 0. A zero result is never reported as negative.
- R4: digit_err is 1 whenever any digit of m_bcd or n_bcd, in any position, holds a code from 1010 to 1111.
- R5: digit_err is 0 when every digit of both operands holds a code from 0000 to 1001.
- R6: With legal operands, every digit of diff_mag is in the range 0000 to 1001.
- R7: The outputs depend only on the present inputs. There is no clock or state, and a new operand pair produces its result in the same cycle.
- R8: At the range extremes, (10^DIGITS - 1) - 0 gives magnitude 10^DIGITS - 1 with diff_neg 0, and 0 - (10^DIGITS - 1) gives the same magnitude with diff_neg 1.
- R9: Borrows propagate across every digit. For example, 1000 - 0001 gives 0999, and 0001 - 1000 gives a negative 0999.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| m_bcd | input | 4*DIGITS | Minuend, packed BCD, digit 0 in bits [3:0] |
| n_bcd | input | 4*DIGITS | Subtrahend, packed BCD, digit 0 in bits [3:0] |
| diff_mag | output | 4*DIGITS | Magnitude of M - N, packed BCD |
| diff_neg | output | 1 | 1 when M - N is negative |
| digit_err | output | 1 | 1 when any operand digit is not a legal BCD code |

## Verification
Every result is due in the same cycle as its operands, because no register lies between the inputs and the outputs. The bench therefore drives each new operand pair on a falling clock edge and reads all three outputs one nanosecond later, well before the next rising edge. Expected values come from converting the operands to integers and subtracting them. The bench never re-runs the digit-wise complement scheme. The bound checker evaluates its properties whenever the combinational outputs settle.

// File: rtl/bcd_sub_pkg.sv
package bcd_sub_pkg;

  localparam int unsigned DIGIT_W = 4;

  // Nine's complement of one decimal digit.
  function automatic logic [3:0] nine_minus(input logic [3:0] d);
    return 4'd9 - d;
  endfunction

  // Decimal digit add: returns {carry_out, corrected_digit}.
  function automatic logic [4:0] digit_sum(input logic [3:0] a,
                                           input logic [3:0] b,
                                           input logic       cin);
    logic [4:0] raw;
    logic       carry;
    logic [3:0] dig;
    raw   = {1'b0, a} + {1'b0, b} + {4'b0000, cin};
    carry = (raw > 5'd9);
    dig   = carry ? (raw[3:0] + 4'd6) : raw[3:0];
    return {carry, dig};
  endfunction

  function automatic logic digit_legal(input logic [3:0] d);
    return (d <= 4'd9);
  endfunction

endpackage

// File: rtl/bcd_nines_comp.sv
module bcd_nines_comp #(
  parameter int unsigned DIGITS = 4
) (
  input  logic [4*DIGITS-1:0] din,
  output logic [4*DIGITS-1:0] dout
);
  import bcd_sub_pkg::*;

  for (genvar k = 0; k < DIGITS; k++) begin : g_digit
    assign dout[DIGIT_W*k +: DIGIT_W] = nine_minus(din[DIGIT_W*k +: DIGIT_W]);
  end
endmodule

// File: rtl/bcd_digit_adder.sv
module bcd_digit_adder (
  input  logic [3:0] a,
  input  logic [3:0] b,
  input  logic       cin,
  output logic [3:0] sum,
  output logic       cout
);
  import bcd_sub_pkg::*;

  logic [4:0] packed_res;
  assign packed_res = digit_sum(a, b, cin);
  assign sum        = packed_res[3:0];
  assign cout       = packed_res[4];
endmodule

// File: rtl/bcd_ripple_adder.sv
module bcd_ripple_adder #(
  parameter int unsigned DIGITS = 4
) (
  input  logic [4*DIGITS-1:0] a,
  input  logic [4*DIGITS-1:0] b,
  input  logic                cin,
  output logic [4*DIGITS-1:0] sum,
  output logic                cout
);
  import bcd_sub_pkg::*;

  logic [DIGITS:0] carry;
  assign carry[0] = cin;

  for (genvar k = 0; k < DIGITS; k++) begin : g_cell
    bcd_digit_adder u_cell (
      .a   (a[DIGIT_W*k +: DIGIT_W]),
      .b   (b[DIGIT_W*k +: DIGIT_W]),
      .cin (carry[k]),
      .sum (sum[DIGIT_W*k +: DIGIT_W]),
      .cout(carry[k+1])
    );
  end

  assign cout = carry[DIGITS];
endmodule

// File: rtl/bcd_digit_check.sv
module bcd_digit_check #(
  parameter int unsigned DIGITS = 4
) (
  input  logic [4*DIGITS-1:0] digits,
  output logic                bad
);
  import bcd_sub_pkg::*;

  logic [DIGITS-1:0] illegal;
  for (genvar k = 0; k < DIGITS; k++) begin : g_chk
    assign illegal[k] = ~digit_legal(digits[DIGIT_W*k +: DIGIT_W]);
  end
  assign bad = |illegal;
endmodule

// File: rtl/bcd_tens_subtractor.sv
module bcd_tens_subtractor #(
  parameter int unsigned DIGITS = 4
) (
  input  logic [4*DIGITS-1:0] m_bcd,
  input  logic [4*DIGITS-1:0] n_bcd,
  output logic [4*DIGITS-1:0] diff_mag,
  output logic                diff_neg,
  output logic                digit_err
);
  localparam int unsigned VEC_W = 4 * DIGITS;

  // Named internal events, visible to the bound checker.
  logic [VEC_W-1:0] n_nines;      // nine's complement of N
  logic [VEC_W-1:0] raw_sum;      // M + 9s(N) + 1
  logic             end_carry;    // carry out of top digit: 1 => M >= N
  logic [VEC_W-1:0] sum_nines;    // nine's complement of raw_sum
  logic [VEC_W-1:0] recomp;       // ten's complement of raw_sum
  logic             recomp_carry; // only set when raw_sum is zero
  logic             m_bad;
  logic             n_bad;

  bcd_nines_comp #(.DIGITS(DIGITS)) u_comp_n (
    .din (n_bcd),
    .dout(n_nines)
  );

  // Add-one of the ten's complement enters as carry into digit 0.
  bcd_ripple_adder #(.DIGITS(DIGITS)) u_main_add (
    .a   (m_bcd),
    .b   (n_nines),
    .cin (1'b1),
    .sum (raw_sum),
    .cout(end_carry)
  );

  bcd_nines_comp #(.DIGITS(DIGITS)) u_comp_sum (
    .din (raw_sum),
    .dout(sum_nines)
  );

  bcd_ripple_adder #(.DIGITS(DIGITS)) u_fix_add (
    .a   (sum_nines),
    .b   ({VEC_W{1'b0}}),
    .cin (1'b1),
    .sum (recomp),
    .cout(recomp_carry)
  );

  bcd_digit_check #(.DIGITS(DIGITS)) u_chk_m (
    .digits(m_bcd),
    .bad   (m_bad)
  );

  bcd_digit_check #(.DIGITS(DIGITS)) u_chk_n (
    .digits(n_bcd),
    .bad   (n_bad)
  );

  assign diff_mag  = end_carry ? raw_sum : recomp;
  assign diff_neg  = ~end_carry & (diff_mag != {VEC_W{1'b0}});
  assign digit_err = m_bad | n_bad;
endmodule

// File: rtl/bcd_tens_subtractor_checker.sv
module bcd_tens_subtractor_checker #(
  parameter int unsigned DIGITS = 4
) (
  input logic [4*DIGITS-1:0] m_bcd,
  input logic [4*DIGITS-1:0] n_bcd,
  input logic [4*DIGITS-1:0] diff_mag,
  input logic                diff_neg,
  input logic                digit_err,
  input logic                end_carry,
  input logic                recomp_carry
);
  logic mag_legal;
  always_comb begin
    mag_legal = 1'b1;
    for (int k = 0; k < DIGITS; k++)
      if (diff_mag[4*k +: 4] > 4'd9) mag_legal = 1'b0;
  end

  always_comb begin
    // R3: zero magnitude is never flagged negative
    assert_zero_positive_R3: assert (!(diff_mag == '0 && diff_neg))
      else $error("zero result flagged negative");
    // R1: an end carry means the result is non-negative
    assert_carry_positive_R1: assert (!(end_carry && diff_neg))
      else $error("end carry with negative sign");
    // R2: a negative result never has a carry out of the re-complement pass
    assert_neg_no_wrap_R2: assert (!(diff_neg && recomp_carry))
      else $error("re-complement carried on negative result");
    // R6: legal operands give legal magnitude digits
    assert_mag_legal_R6: assert (digit_err || mag_legal)
      else $error("illegal digit in magnitude");
    // R3: identical legal operands give zero
    assert_equal_zero_R3: assert (digit_err || m_bcd != n_bcd || diff_mag == '0)
      else $error("equal operands gave nonzero result");
  end
endmodule

bind bcd_tens_subtractor bcd_tens_subtractor_checker #(.DIGITS(DIGITS)) u_checker (
  .m_bcd       (m_bcd),
  .n_bcd       (n_bcd),
  .diff_mag    (diff_mag),
  .diff_neg    (diff_neg),
  .digit_err   (digit_err),
  .end_carry   (end_carry),
  .recomp_carry(recomp_carry)
);

// File: tb/bcd_tens_subtractor_bench.sv
`timescale 1ns/1ps
module bcd_tens_subtractor_bench;
  localparam int D   = 4;
  localparam int W   = 4 * D;
  localparam int MAXV = 9999;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] m_bcd = '0;
  logic [W-1:0] n_bcd = '0;
  logic [W-1:0] diff_mag;
  logic         diff_neg;
  logic         digit_err;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2 clk = ~clk;  // 250 MHz

  bcd_tens_subtractor #(.DIGITS(D)) u_bcd_tens_subtractor (
    .m_bcd    (m_bcd),
    .n_bcd    (n_bcd),
    .diff_mag (diff_mag),
    .diff_neg (diff_neg),
    .digit_err(digit_err)
  );

  function automatic logic [W-1:0] to_bcd(input int v);
    logic [W-1:0] r;
    int t;
    t = v;
    r = '0;
    for (int k = 0; k < D; k++) begin
      r[4*k +: 4] = 4'(t % 10);
      t = t / 10;
    end
    return r;
  endfunction

  task automatic apply(input logic [W-1:0] m, input logic [W-1:0] n);
    @(negedge clk);
    m_bcd = m;
    n_bcd = n;
    #1;
  endtask

  task automatic check_bit(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %b expected %b (m=%h n=%h)", req, act, exp, m_bcd, n_bcd);
    end
  endtask

  task automatic check_vec(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h (m=%h n=%h)", req, act, exp, m_bcd, n_bcd);
    end
  endtask

  // Integer reference: sign and magnitude of m - n.
  task automatic sub_check(input string req, input int m, input int n);
    int d;
    apply(to_bcd(m), to_bcd(n));
    d = m - n;
    check_vec(req, diff_mag, to_bcd(d < 0 ? -d : d));
    check_bit(req, diff_neg, d < 0);
    check_bit("R5", digit_err, 1'b0);
  endtask

  task automatic t_reset_state;
    apply('0, '0);
    check_vec("R3 reset", diff_mag, '0);
    check_bit("R3 reset", diff_neg, 1'b0);
    check_bit("R5 reset", digit_err, 1'b0);
  endtask

  task automatic t_positive;
    sub_check("R1", 7253, 1325);
    sub_check("R1", 5000, 4999);
    sub_check("R1", 42, 0);
  endtask

  task automatic t_negative;
    sub_check("R2", 1325, 7253);
    sub_check("R2", 4999, 5000);
    sub_check("R2", 0, 42);
  endtask

  task automatic t_equal;
    sub_check("R3", 3737, 3737);
    sub_check("R3", 9999, 9999);
  endtask

  task automatic t_extremes;
    sub_check("R8", MAXV, 0);
    sub_check("R8", 0, MAXV);
  endtask

  task automatic t_borrow_chain;
    sub_check("R9", 1000, 1);
    sub_check("R9", 1, 1000);
    sub_check("R9", 9000, 8999);
  endtask

  task automatic t_invalid;
    for (int k = 0; k < D; k++) begin
      logic [W-1:0] bad;
      bad = to_bcd(1234);
      bad[4*k +: 4] = 4'(10 + k);
      apply(bad, to_bcd(17));
      check_bit("R4 m digit", digit_err, 1'b1);
      apply(to_bcd(17), bad);
      check_bit("R4 n digit", digit_err, 1'b1);
    end
    apply({W{1'b1}}, {W{1'b1}});
    check_bit("R4 all ones", digit_err, 1'b1);
  endtask

  task automatic t_combinational;
    // R7: result follows each new pair without any clock edge
    m_bcd = to_bcd(8000); n_bcd = to_bcd(1);
    #1;
    check_vec("R7", diff_mag, to_bcd(7999));
    m_bcd = to_bcd(1); n_bcd = to_bcd(8000);
    #1;
    check_vec("R7", diff_mag, to_bcd(7999));
    check_bit("R7", diff_neg, 1'b1);
  endtask

  task automatic t_random;
    for (int i = 0; i < 300; i++) begin
      int a, b;
      a = int'($urandom % (MAXV + 1));
      b = int'($urandom % (MAXV + 1));
      sub_check(a >= b ? "R1 rand" : "R2 rand", a, b);
      for (int k = 0; k < D; k++)
        check_bit("R6", diff_mag[4*k +: 4] <= 4'd9, 1'b1);
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    t_reset_state();
    t_positive();
    t_negative();
    t_equal();
    t_extremes();
    t_borrow_chain();
    t_invalid();
    t_combinational();
    t_random();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule